// File: doc/BRIEF.md
# Single-Precision Rounding Stage

This block takes a single-precision result that an arithmetic unit has already aligned, but not yet rounded, and turns it into the final 32-bit encoding. Each item carries a sign, an 8-bit biased exponent, a 23-bit fraction and three extra low-order bits: guard, round and sticky. A 2-bit mode field travels with each item and selects one of the four IEEE 754 rounding directions. Besides the rounded word, the block reports whether precision was lost and whether rounding carried the value into the infinity encoding.

Items enter and leave on valid/ready streams. An item is taken when `in_valid` and `in_ready` are both high at a rising clock edge. It is delivered when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output word and its flags hold still. With the default parameter setting the block holds one item in a register. In that case `in_ready` is high whenever that register is empty or is being drained in the same cycle. With `REG_OUT` set to 0 the block is purely combinational and both handshakes pass straight through.

Denormal inputs (exponent 0) are rounded as they are, with the fraction taken at face value. They are not normalised first.

Top module: `fp_round_unit`

## Requirements
- R1: Mode code 00 rounds to nearest. If the guard bit is 0 the fraction is kept. If guard is 1 and round or sticky is 1 the fraction is incremented. The input layout is `in_sig[25:3]` for the fraction, `in_sig[2]` for guard, `in_sig[1]` for round and `in_sig[0]` for sticky.
- R2: In mode 00, an exact half (guard 1, round 0, sticky 0) picks the neighbour whose fraction LSB is 0. The fraction is incremented only when its LSB is 1.
- R3: Mode code 01 rounds toward minus infinity. A negative value with lost bits grows by one unit in magnitude. A positive value is truncated.
- R4: Mode code 10 rounds toward plus infinity. A positive value with lost bits grows by one unit. A negative value is truncated.
- R5: Mode code 11 truncates toward zero. The fraction and exponent are never incremented.
- R6: For an exponent below 255, `out_inexact` is 1 exactly when any of guard, round or sticky is 1.
- R7: When guard, round and sticky are all 0, the sign, exponent and fraction leave unchanged, with both flags at 0.
- R8: When incrementing a fraction of all ones carries out of the significand, the fraction becomes 0 and the exponent rises by one. This also applies to denormals, which move from exponent 0 to exponent 1.
- R9: When that carry makes the exponent 255, `out_overflow` is 1 and the result is the infinity of the input's sign. In every other case `out_overflow` is 0.
- R10: An input with exponent 255 (infinity or NaN) passes through as `{sign, 255, in_sig[25:3]}` in every mode. Its extra bits are dropped, and `out_inexact` and `out_overflow` are 0.
- R11: After reset `out_valid` is 0 and `in_ready` is 1. While `out_valid` is high and `out_ready` is low, the output holds its value and no further item is taken. Items leave in the order they entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an item this cycle |
| in_sign | input | 1 | Sign of the unrounded value |
| in_exp | input | 8 | Biased exponent |
| in_sig | input | 26 | Fraction (25:3), guard (2), round (1), sticky (0) |
| in_mode | input | 2 | Rounding direction: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero |
| out_valid | output | 1 | Output item present |
| out_ready | input | 1 | Consumer takes the output item this cycle |
| out_result | output | 32 | Rounded encoding {sign, exponent, fraction} |
| out_inexact | output | 1 | Precision was lost |
| out_overflow | output | 1 | Rounding carried the value into infinity |

## Verification
The combinational checks beside the rounding logic assume that every input bit is a known value whenever they are evaluated, including at time zero. They also assume that the mode field only ever holds one of its four legal codes, which a 2-bit field guarantees. The stimulus therefore drives every input to a defined value from the first instant, and holds each item steady from the moment it is offered until it is taken. The output-hold property depends only on the consumer's ready signal. Random and forced back-pressure exercise it without any constraint on the producer.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  // Rounding direction codes; the two directed codes are ordered by sign of travel.
  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_CHOP = 2'b11
  } rnd_mode_e;

  localparam int EXTRA_W = 3;  // guard, round, sticky

endpackage

// File: rtl/fpr_decide.sv
module fpr_decide
  import fpr_pkg::*;
(
  input  logic                 sign,
  input  logic                 special,
  input  logic                 frac_lsb,
  input  logic [EXTRA_W-1:0]   grs,
  input  rnd_mode_e            mode,
  output logic                 bump,
  output logic                 lost
);

  logic half_bit;
  logic below_half;

  always_comb begin
    half_bit   = grs[EXTRA_W-1];
    below_half = |grs[EXTRA_W-2:0];
    lost       = !special && (half_bit || below_half);
    bump       = 1'b0;
    case (mode)
      RND_NEAR: bump = half_bit && (below_half || frac_lsb);
      RND_DOWN: bump = sign && lost;
      RND_UP:   bump = !sign && lost;
      default:  bump = 1'b0;
    endcase
    if (special) bump = 1'b0;
  end

endmodule

// File: rtl/fpr_apply.sv
module fpr_apply #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W-1:0]  exp_in,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic              bump,
  output logic [EXP_W-1:0]  exp_out,
  output logic [FRAC_W-1:0] frac_out,
  output logic              ovf
);

  localparam logic [EXP_W-1:0] EXP_TOP = '1;

  logic [FRAC_W:0] sum;

  always_comb begin
    sum      = {1'b0, frac_in} + {{FRAC_W{1'b0}}, bump};
    frac_out = sum[FRAC_W-1:0];
    exp_out  = exp_in + {{(EXP_W-1){1'b0}}, sum[FRAC_W]};
    ovf      = sum[FRAC_W] && (exp_out == EXP_TOP);
  end

  // R7: without an increment nothing about the magnitude may change
  always_comb begin
    if (!bump) begin
      assert_exact_keep_R7: assert (frac_out == frac_in && exp_out == exp_in && !ovf);
    end
  end

  // R9: an overflow must leave the infinity encoding behind it
  always_comb begin
    if (ovf) begin
      assert_overflow_inf_R9: assert (exp_out == EXP_TOP && frac_out == '0);
    end
  end

endmodule

// File: rtl/fpr_stage.sv
module fpr_stage #(
  parameter int W       = 34,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  generate
    if (REG_OUT) begin : g_reg
      logic         full;
      logic [W-1:0] hold_q;

      assign in_ready  = !full || out_ready;
      assign out_valid = full;
      assign out_data  = hold_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          full <= 1'b0;
        end else if (in_ready) begin
          full <= in_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (in_valid && in_ready) hold_q <= in_data;
      end

      // R11: a stalled output item stays put
      assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fpr_pkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_sign,
  input  logic [EXP_W-1:0]          in_exp,
  input  logic [FRAC_W+EXTRA_W-1:0] in_sig,
  input  logic [1:0]                in_mode,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [EXP_W+FRAC_W:0]     out_result,
  output logic                      out_inexact,
  output logic                      out_overflow
);

  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int STAGE_W = WORD_W + 2;

  rnd_mode_e         mode;
  logic              special;
  logic [FRAC_W-1:0] frac_in;
  logic [EXTRA_W-1:0] grs;
  logic              bump;
  logic              lost;
  logic [EXP_W-1:0]  res_exp;
  logic [FRAC_W-1:0] res_frac;
  logic              ovf;
  logic [STAGE_W-1:0] stage_in;
  logic [STAGE_W-1:0] stage_out;

  assign mode    = rnd_mode_e'(in_mode);
  assign special = &in_exp;
  assign frac_in = in_sig[FRAC_W+EXTRA_W-1:EXTRA_W];
  assign grs     = in_sig[EXTRA_W-1:0];

  fpr_decide u_decide (
    .sign     (in_sign),
    .special  (special),
    .frac_lsb (frac_in[0]),
    .grs      (grs),
    .mode     (mode),
    .bump     (bump),
    .lost     (lost)
  );

  fpr_apply #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_apply (
    .exp_in   (in_exp),
    .frac_in  (frac_in),
    .bump     (bump),
    .exp_out  (res_exp),
    .frac_out (res_frac),
    .ovf      (ovf)
  );

  assign stage_in = {ovf, lost, in_sign, res_exp, res_frac};

  fpr_stage #(.W(STAGE_W), .REG_OUT(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (stage_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (stage_out)
  );

  assign out_overflow = stage_out[STAGE_W-1];
  assign out_inexact  = stage_out[STAGE_W-2];
  assign out_result   = stage_out[WORD_W-1:0];

  // R2: a tie in nearest mode must land on an even fraction
  always_comb begin
    if (mode == RND_NEAR && !special && grs == 3'b100) begin
      assert_tie_even_R2: assert (res_frac[0] == 1'b0);
    end
  end

  // R3, R4, R5: an increment only ever moves away from zero in the sign's permitted direction
  always_comb begin
    if (bump) begin
      assert_direction_R4: assert (mode != RND_CHOP &&
                                   !(mode == RND_UP && in_sign) &&
                                   !(mode == RND_DOWN && !in_sign));
    end
  end

endmodule

// File: tb/fp_round_unit_test.sv
module fp_round_unit_test;

  localparam int SIGW = 26;

  typedef struct {
    logic [31:0] res;
    logic        ix;
    logic        ov;
    string       tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic            in_sign = 1'b0;
  logic [7:0]      in_exp = '0;
  logic [SIGW-1:0] in_sig = '0;
  logic [1:0]      in_mode = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [31:0]     out_result;
  logic            out_inexact;
  logic            out_overflow;

  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  bit   stall = 1'b0;
  bit   bp = 1'b0;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  fp_round_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_inexact(out_inexact), .out_overflow(out_overflow)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exv);
    end
  endtask

  // Consumer ready: changes 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (stall) out_ready <= 1'b0;
    else if (bp) out_ready <= (($urandom % 3) != 0);
    else out_ready <= 1'b1;
  end

  // Monitor: compare every delivered item with the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R11 unexpected output", out_result, 32'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(out_result == e.res, {e.tag, " result"}, out_result, e.res);
        chk(out_inexact == e.ix, {e.tag, " inexact R6"}, {31'h0, out_inexact}, {31'h0, e.ix});
        chk(out_overflow == e.ov, {e.tag, " overflow R9"}, {31'h0, out_overflow}, {31'h0, e.ov});
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      chk(1'b0, "R11 watchdog expired", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Independent model of the requirements
  function automatic void model(input bit s, input bit [7:0] e, input bit [SIGW-1:0] x,
                                input bit [1:0] m, output bit [31:0] r, output bit ix,
                                output bit ov);
    bit g, tail, up;
    bit [30:0] mag;
    if (e == 8'hFF) begin
      r = {s, e, x[25:3]}; ix = 1'b0; ov = 1'b0;
    end else begin
      g = x[2];
      tail = x[1] | x[0];
      case (m)
        2'b00: up = g && (tail || x[3]);
        2'b01: up = s && (g || tail);
        2'b10: up = !s && (g || tail);
        default: up = 1'b0;
      endcase
      mag = {e, x[25:3]} + {30'h0, up};
      r = {s, mag};
      ix = g || tail;
      ov = up && (mag[30:23] == 8'hFF);
    end
  endfunction

  // Driver: offer one item, hold it until taken, then record the expectation
  task automatic send(input bit s, input bit [7:0] e, input bit [SIGW-1:0] x, input bit [1:0] m,
                      input bit [31:0] r, input bit ix, input bit ov, input string tag);
    bit ok;
    exp_t it;
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_exp = e; in_sig = x; in_mode = m;
    do begin
      #1 ok = in_ready;
      @(posedge clk);
      if (!ok) @(negedge clk);
    end while (!ok);
    it.res = r; it.ix = ix; it.ov = ov; it.tag = tag;
    sbq.push_back(it);
    #0.5 in_valid = 1'b0;
  endtask

  task automatic send_m(input bit s, input bit [7:0] e, input bit [SIGW-1:0] x, input bit [1:0] m,
                        input string tag);
    bit [31:0] r;
    bit ix, ov;
    model(s, e, x, m, r, ix, ov);
    send(s, e, x, m, r, ix, ov, tag);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 reset out_valid", {31'h0, out_valid}, 32'h0);
    chk(in_ready == 1'b1, "R11 reset in_ready", {31'h0, in_ready}, 32'h1);

    // Directed corner cases with hand-worked values
    send(0, 8'd127, 26'h0000003, 2'b00, 32'h3F800000, 1, 0, "R1 below half");
    send(0, 8'd127, 26'h0000005, 2'b00, 32'h3F800001, 1, 0, "R1 above half");
    send(0, 8'd127, 26'h0000004, 2'b00, 32'h3F800000, 1, 0, "R2 tie even stays");
    send(0, 8'd127, 26'h000000C, 2'b00, 32'h3F800002, 1, 0, "R2 tie odd bumps");
    send(1, 8'd127, 26'h0000001, 2'b01, 32'hBF800001, 1, 0, "R3 negative grows");
    send(0, 8'd127, 26'h0000001, 2'b01, 32'h3F800000, 1, 0, "R3 positive chops");
    send(0, 8'd127, 26'h0000001, 2'b10, 32'h3F800001, 1, 0, "R4 positive grows");
    send(1, 8'd127, 26'h0000001, 2'b10, 32'hBF800000, 1, 0, "R4 negative chops");
    send(1, 8'd127, 26'h3FFFFFF, 2'b11, 32'hBFFFFFFF, 1, 0, "R5 truncate");
    send(1, 8'd130, 26'h091A2B0, 2'b10, 32'hC1123456, 0, 0, "R7 exact");
    send(0, 8'd127, 26'h3FFFFFC, 2'b00, 32'h40000000, 1, 0, "R8 carry");
    send(0, 8'd0,   26'h3FFFFFC, 2'b00, 32'h00800000, 1, 0, "R8 denormal carry");
    send(0, 8'd254, 26'h3FFFFFC, 2'b00, 32'h7F800000, 1, 1, "R9 overflow up");
    send(1, 8'd254, 26'h3FFFFFC, 2'b01, 32'hFF800000, 1, 1, "R9 overflow down");
    send(1, 8'd254, 26'h3FFFFFC, 2'b10, 32'hFF7FFFFF, 1, 0, "R9 no overflow toward zero");
    send(0, 8'd255, 26'h2000007, 2'b10, 32'h7FC00000, 0, 0, "R10 NaN passthrough");
    send(1, 8'd255, 26'h0000007, 2'b00, 32'hFF800000, 0, 0, "R10 infinity passthrough");
    drain();

    // Forced stall: output must hold and input must close
    @(negedge clk);
    stall = 1'b1;
    @(posedge clk);
    #2;
    send(0, 8'd100, 26'h0000005, 2'b00, 32'h32000001, 1, 0, "R11 stalled item");
    @(negedge clk);
    begin
      logic [31:0] held;
      held = out_result;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(out_valid && out_result == held, "R11 hold under stall", out_result, held);
        chk(in_ready == 1'b0, "R11 input closed", {31'h0, in_ready}, 32'h0);
      end
    end
    stall = 1'b0;
    drain();

    // Random items under random back-pressure, checked against the model
    bp = 1'b1;
    for (int n = 0; n < 400; n++) begin
      bit [7:0] e;
      bit [SIGW-1:0] x;
      case ($urandom % 6)
        0: e = 8'd0;
        1: e = 8'd254;
        2: e = 8'd255;
        default: e = 8'($urandom);
      endcase
      x = SIGW'($urandom);
      if (($urandom % 4) == 0) x[25:3] = '1;
      if (($urandom % 5) == 0) x[2:0] = 3'b100;
      send_m(1'($urandom), e, x, 2'($urandom), "R6 random");
    end
    bp = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule